// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a 32-bit processor core and picks its next value on every clock. The top bit of the counter is not an address bit: it is the privilege flag. When it is set the core runs in supervisor mode and when it is clear the core runs in user mode. The low 31 bits hold a word-aligned byte address. Each cycle the decode stage tells the block what kind of instruction is executing. It also supplies the 16-bit literal from that instruction, the value read from the first source register, and any pending exception request with its vector.

From these inputs the block produces three things. The first is the current counter. The second is the link value (the address after the current one), which the register file stores for branches and jumps. The third is the value to save in the exception-pointer register, together with a strobe that is high in any cycle where an exception is accepted. Register jumps may drop the core from supervisor to user mode but can never raise it. Only an accepted exception, or reset, enters supervisor mode.

The asynchronous active-low reset is released through a two-stage synchronizer. The counter therefore first moves on the third rising edge after `rst_n` rises.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is active, and up to the second rising clock edge after `rst_n` goes high, `pc` is 0x8000_0000: address 0 with the supervisor bit (bit 31) set.
- R2: With `kind` = 2'b00 (sequential) and no accepted exception, the next `pc` keeps bit 31 and sets bits 30:0 to bits 30:0 of `pc` plus 4, modulo 2^31.
- R3: A taken branch loads bit 31 unchanged and sets bits 30:0 to the bits 30:0 of `link` plus the sign-extended `literal` shifted left by two, modulo 2^31.
- R4: With `kind` = 2'b01 the branch is taken exactly when `ra_value` is zero. With `kind` = 2'b10 it is taken exactly when `ra_value` is non-zero. An untaken branch behaves like R2.
- R5: `link` always equals bit 31 of `pc` joined to bits 30:0 of `pc` plus 4. This holds for every `kind`, whether or not a branch is taken.
- R6: With `kind` = 2'b11 (register jump) and no accepted exception, next `pc` bits 30:2 come from `ra_value` bits 30:2, and bits 1:0 become zero.
- R7: A register jump sets the new bit 31 to the old bit 31 ANDed with `ra_value` bit 31. No path other than an exception or reset sets bit 31.
- R8: When `exc_req` is high and `pc` bit 31 is clear, `exc_taken` is high and `xp_value` equals `link`. The next `pc` is `exc_vector` with bits 1:0 cleared and bit 31 set.
- R9: When `pc` bit 31 is set, `exc_req` has no effect: `exc_taken` stays low and `pc` follows the instruction kind.
- R10: An accepted exception takes priority over any branch or jump presented in the same cycle.
- R11: Bits 1:0 of `pc` are zero in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kind | input | 2 | Instruction kind: 00 sequential, 01 branch if zero, 10 branch if non-zero, 11 register jump |
| literal | input | 16 | Signed word displacement of a branch |
| ra_value | input | 32 | Value of the first source register |
| exc_req | input | 1 | Exception request (trap, fault or interrupt) |
| exc_vector | input | 32 | Handler address for the requested exception |
| pc | output | 32 | Current program counter, bit 31 the supervisor flag |
| link | output | 32 | Address of the following instruction, for the link write |
| xp_value | output | 32 | Value to store in the exception pointer |
| exc_taken | output | 1 | High in a cycle where an exception is accepted |

## Verification
The bench targets the following corner cases:

- **Offset sum crossing bit 30.** A branch whose offset sum carries out of bit 30 is run in both modes. A design that let the carry reach the flag would switch privilege on a plain branch.
- **Jump with set low bits and a set top bit.** A jump from user mode uses a register value with both low bits and the top bit set. A design that omitted the mask would fetch misaligned, and one that copied bit 31 would grant supervisor mode.
- **Exception in supervisor mode.** An exception raised here must be ignored. A design that accepted it would overwrite the saved return address.
- **Exception together with a taken branch.** Both arrive in the same cycle. A design with the wrong priority would land on the branch target instead of the vector.
- **Branches on zero and non-zero registers.** Both branch kinds see zero and non-zero register values, with positive and negative displacements. This exposes swapped conditions and unsigned offsets.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [1:0] {
    KIND_SEQ  = 2'b00,
    KIND_BZ   = 2'b01,
    KIND_BNZ  = 2'b10,
    KIND_JUMP = 2'b11
  } pc_kind_e;

endpackage

// File: rtl/pcseq_rst_sync.sv
module pcseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
  parameter int ADDR_W = 32,
  parameter int LIT_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [LIT_W-1:0]  literal,
  input  logic [ADDR_W-1:0] ra_value,
  output logic [ADDR_W-1:0] pc_inc,
  output logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] jmp_target
);

  localparam int LOW_W = ADDR_W - 1;
  localparam int EXT_W = LOW_W - LIT_W - 2;
  localparam logic [LOW_W-1:0]  WORD_STEP = LOW_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_CLR = ~ADDR_W'(3);

  logic              sup_bit;
  logic [LOW_W-1:0]  inc_low;
  logic [LOW_W-1:0]  byte_off;
  logic [LOW_W-1:0]  br_low;
  logic [ADDR_W-1:0] sup_keep;

  always_comb begin
    sup_bit  = pc_cur[ADDR_W-1];
    inc_low  = pc_cur[LOW_W-1:0] + WORD_STEP;
    pc_inc   = {sup_bit, inc_low};
    byte_off = {{EXT_W{literal[LIT_W-1]}}, literal, 2'b00};
    br_low   = inc_low + byte_off;
    br_target = {sup_bit, br_low};
    // top bit may only survive if it was already set
    sup_keep   = {sup_bit, {LOW_W{1'b1}}};
    jmp_target = ra_value & ALIGN_CLR & sup_keep;
  end

endmodule

// File: rtl/pcseq_select.sv
module pcseq_select
  import pcseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pc_kind_e          kind,
  input  logic [ADDR_W-1:0] ra_value,
  input  logic              sup_mode,
  input  logic [ADDR_W-1:0] pc_inc,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] jmp_target,
  input  logic              exc_req,
  input  logic [ADDR_W-1:0] exc_vector,
  output logic [ADDR_W-1:0] pc_next,
  output logic              exc_taken
);

  localparam logic [ADDR_W-1:0] ALIGN_CLR = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] SUP_SET   = {1'b1, {(ADDR_W-1){1'b0}}};

  logic ra_zero;
  logic branch_go;

  always_comb begin
    ra_zero   = (ra_value == '0);
    branch_go = ((kind == KIND_BZ) && ra_zero) ||
                ((kind == KIND_BNZ) && !ra_zero);
    exc_taken = exc_req && !sup_mode;
    if (exc_taken) begin
      pc_next = (exc_vector & ALIGN_CLR) | SUP_SET;
    end else if (kind == KIND_JUMP) begin
      pc_next = jmp_target;
    end else if (branch_go) begin
      pc_next = br_target;
    end else begin
      pc_next = pc_inc;
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LIT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind,
  input  logic [LIT_W-1:0]  literal,
  input  logic [ADDR_W-1:0] ra_value,
  input  logic              exc_req,
  input  logic [ADDR_W-1:0] exc_vector,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] xp_value,
  output logic              exc_taken
);

  localparam int MSB = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] RESET_PC  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] ALIGN_CLR = ~ADDR_W'(3);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] br_target;
  logic [ADDR_W-1:0] jmp_target;
  logic [ADDR_W-1:0] pc_next;
  pc_kind_e          kind_e;

  pcseq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcseq_target #(.ADDR_W(ADDR_W), .LIT_W(LIT_W)) u_target (
    .pc_cur     (pc_q),
    .literal    (literal),
    .ra_value   (ra_value),
    .pc_inc     (pc_inc),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  assign kind_e = pc_kind_e'(kind);

  pcseq_select #(.ADDR_W(ADDR_W)) u_select (
    .kind       (kind_e),
    .ra_value   (ra_value),
    .sup_mode   (pc_q[MSB]),
    .pc_inc     (pc_inc),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .exc_req    (exc_req),
    .exc_vector (exc_vector),
    .pc_next    (pc_next),
    .exc_taken  (exc_taken)
  );

  always_comb begin
    pc_d = pc_next;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc       = pc_q;
  assign link     = pc_inc;
  assign xp_value = pc_inc;

  // R11: counter stays word aligned
  a_r11_word_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_q[1:0] == 2'b00);

  // R7: privilege is never gained without an exception
  a_r7_no_sup_gain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pc_q[MSB] && !exc_taken) |=> !pc_q[MSB]);

  // R8 / R10: accepted exception lands on the vector in supervisor mode
  a_r8_exc_to_vector: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_taken |=> pc_q == (($past(exc_vector) & ALIGN_CLR) | RESET_PC));

  // R2: sequential step follows the link value
  a_r2_seq_follows_link: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kind == 2'b00 && !exc_taken) |=> pc_q == $past(link));

  // R6: jump takes the register's word address
  a_r6_jump_word: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (kind == 2'b11 && !exc_taken) |=>
      (pc_q[MSB-1:2] == $past(ra_value[MSB-1:2]) && pc_q[1:0] == 2'b00));

endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  kind;
  logic [15:0] lit;
  logic [31:0] ra_value;
  logic        exc_req;
  logic [31:0] exc_vector;
  logic [31:0] pc;
  logic [31:0] link;
  logic [31:0] xp_value;
  logic        exc_taken;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  pc_sequencer uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .literal    (lit),
    .ra_value   (ra_value),
    .exc_req    (exc_req),
    .exc_vector (exc_vector),
    .pc         (pc),
    .link       (link),
    .xp_value   (xp_value),
    .exc_taken  (exc_taken)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] k, logic [15:0] l, logic [31:0] ra,
                      logic e, logic [31:0] v, string tag);
    logic [31:0] mp4, off, bt, nxt;
    logic take;
    @(negedge clk);
    kind = k; lit = l; ra_value = ra; exc_req = e; exc_vector = v;
    #1;
    mp4  = {m_pc[31], m_pc[30:0] + 31'd4};
    take = e && !m_pc[31];
    chk("R5 link", link, mp4);
    if (take) begin
      chk("R8 exc_taken", {31'b0, exc_taken}, 32'd1);
      chk("R8 xp_value", xp_value, mp4);
    end else begin
      chk(e ? "R9 exc_taken" : "R8 exc_taken idle", {31'b0, exc_taken}, 32'd0);
    end
    off = {{14{l[15]}}, l, 2'b00};
    bt  = {m_pc[31], mp4[30:0] + off[30:0]};
    if (take) nxt = (v & 32'hFFFF_FFFC) | 32'h8000_0000;
    else case (k)
      2'b00:   nxt = mp4;
      2'b01:   nxt = (ra == 0) ? bt : mp4;
      2'b10:   nxt = (ra != 0) ? bt : mp4;
      default: nxt = {m_pc[31] & ra[31], ra[30:2], 2'b00};
    endcase
    @(posedge clk);
    #1;
    m_pc = nxt;
    chk(tag, pc, m_pc);
    chk("R11 aligned", {30'b0, pc[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; kind = 2'b00; lit = '0; ra_value = '0;
    exc_req = 1'b0; exc_vector = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", pc, 32'h8000_0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 held after release 1", pc, 32'h8000_0000);
    @(posedge clk); #1;
    chk("R1 held after release 2", pc, 32'h8000_0000);
    m_pc = 32'h8000_0000;

    step(2'b00, 16'h0000, 32'h0, 1'b0, 32'h0, "R2 seq");
    step(2'b00, 16'h1234, 32'h5, 1'b0, 32'h0, "R2 seq");
    step(2'b01, 16'h0010, 32'h0, 1'b0, 32'h0, "R3 R4 bz taken fwd");
    step(2'b01, 16'hFFFD, 32'h0, 1'b0, 32'h0, "R3 R4 bz taken back");
    step(2'b01, 16'h0040, 32'h1, 1'b0, 32'h0, "R4 bz not taken");
    step(2'b10, 16'h0008, 32'h8000_0000, 1'b0, 32'h0, "R4 bnz taken");
    step(2'b10, 16'h0008, 32'h0, 1'b0, 32'h0, "R4 bnz not taken");
    step(2'b00, 16'h0, 32'h0, 1'b1, 32'h0000_0100, "R9 exc ignored in sup");
    step(2'b11, 16'h0, 32'hFFFF_FFF3, 1'b0, 32'h0, "R6 R7 jump keeps sup");
    step(2'b00, 16'h0, 32'h0, 1'b0, 32'h0, "R2 seq near top");
    step(2'b01, 16'h0008, 32'h0, 1'b0, 32'h0, "R3 wrap keeps sup");
    step(2'b11, 16'h0, 32'h7FFF_FFF2, 1'b0, 32'h0, "R6 R7 jump to user");
    step(2'b01, 16'h0008, 32'h0, 1'b0, 32'h0, "R3 wrap stays user");
    step(2'b11, 16'h0, 32'hC000_0107, 1'b0, 32'h0, "R7 jump cannot raise");
    step(2'b01, 16'h0020, 32'h0, 1'b1, 32'h0000_0083, "R10 exc beats branch");
    step(2'b11, 16'h0, 32'h0000_0400, 1'b0, 32'h0, "R6 back to user");
    step(2'b11, 16'h0, 32'h0000_0800, 1'b1, 32'h0000_0040, "R10 exc beats jump");
    step(2'b11, 16'h0, 32'h0000_0200, 1'b0, 32'h0, "R6 back to user");
    step(2'b00, 16'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R8 exc vector");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (($urandom % 4) == 0) r = 32'h0;
      step(2'($urandom), 16'($urandom), r, (($urandom % 8) == 0),
           $urandom, "R2 R3 R4 R6 R8 mixed");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule